// File: doc/BRIEF.md
# DTMF Guard-Timed Key Register

This block sits behind a tone-pair classifier. The classifier supplies a "pair detected" flag together with a two-bit row index and a two-bit column index. The block decides when a detected pair has lasted long enough to count as a key press. It then turns the pair into a four-bit key code and holds that code until the tone has clearly ended.

Duration checking uses two tick counters instead of an external RC network. Both run on a slow prescaled enable, `tick`, which is typically 1 ms wide.

- The presence counter must run to its limit without interruption before a key is registered.
- The absence counter must run to its limit before the block frees itself for the next key. Short gaps inside a key are therefore bridged.
- A settle counter, measured in clock cycles, delays the "key valid" strobe so that the code is stable before the strobe rises.
- An input can block the four letter keys.
- A power-down input returns the sequencer to idle.
- The code bus is modelled as data plus a drive-enable output. The data reads zero whenever the bus is not driven.

Top module: `tone_guard_latch`

## Requirements
- R1: A pair is registered only after `tone_valid` has stayed high for `PRESENT_TICKS` ticks without a break. A shorter burst leaves `code_out` unchanged and `key_strobe` low.
- R2: After registration, a low period on `tone_valid` shorter than `ABSENT_TICKS` ticks neither lowers `key_strobe` nor registers a new pair, even if the indices change.
- R3: The key codes are as follows. Row index 0..3 selects the 697/770/852/941 Hz group and column index 0..3 selects the 1209/1336/1477/1633 Hz group.
  - Digits 1..9 (rows 0..2, columns 0..2, read row by row) give 0001..1001.
  - Row 3 gives `*` = 1011, `0` = 1010 and `#` = 1100 in columns 0, 1 and 2.
  - Column 3 gives A = 1101, B = 1110, C = 1111 and D = 0000 in rows 0..3.
  - After reset the latched code is 0000.
- R4: `key_strobe` rises `SETTLE_CYCLES` clock cycles after the code latch updates. The latched code only changes while `key_strobe` is low.
- R5: While `letter_block` is high, pairs in column 3 (A..D) are not registered and the previous code is kept. Other keys register normally.
- R6: When `out_en` is low, `code_drive` is 0 and `code_out` reads 0000. When `out_en` is high, `code_drive` is 1 and `code_out` shows the latched code.
- R7: While `pwr_down` is high, `key_strobe` is low in the cycle after it is sampled, no pair is registered, and the latched code is kept. After `pwr_down` falls, keys register normally again.
- R8: After `tone_valid` has been low for `ABSENT_TICKS` ticks, `key_strobe` falls and a new pair can be registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Standby; forces the sequencer idle |
| tick | input | 1 | One-cycle prescaled timing enable |
| tone_valid | input | 1 | Classifier reports a valid tone pair |
| tone_row | input | 2 | Low-group index 0..3 |
| tone_col | input | 2 | High-group index 0..3 |
| letter_block | input | 1 | Blocks registration of column-3 keys |
| out_en | input | 1 | Enables driving of the code bus |
| code_out | output | 4 | Latched key code, zero when not driven |
| code_drive | output | 1 | Bus drive enable for the pad tristate |
| key_strobe | output | 1 | Delayed key-valid strobe |

## Verification
The bench builds the block with `PRESENT_TICKS=5`, `ABSENT_TICKS=4` and `SETTLE_CYCLES=6`, and pulses `tick` every fourth clock. With these values both guard windows complete within a few dozen cycles. This lets a single run walk all sixteen keys. It also fits bursts that fall short of the presence window and dropouts that fall inside the absence window, each with a comfortable margin on either side of the limit, and leaves room for inhibit and power-down sequences between presses.

// File: rtl/tone_guard_pkg.sv
package tone_guard_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_HELD    = 2'd2,
        ST_ABSENT  = 2'd3
    } steer_state_e;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } key_idx_t;

    // Letter keys live in the last column
    function automatic logic is_letter(key_idx_t k);
        return k.col == 2'd3;
    endfunction

    function automatic logic [CODE_W-1:0] key_to_code(key_idx_t k);
        logic [CODE_W-1:0] c;
        if (k.col == 2'd3) begin
            // A..C -> 13..15, D wraps to 0
            c = {2'b11, k.row} + 4'd1;
        end else if (k.row == 2'd3) begin
            case (k.col)
                2'd0:    c = 4'd11;
                2'd1:    c = 4'd10;
                default: c = 4'd12;
            endcase
        end else begin
            c = ({2'b00, k.row} * 4'd3) + {2'b00, k.col} + 4'd1;
        end
        return c;
    endfunction

endpackage

// File: rtl/tg_tick_timer.sv
module tg_tick_timer #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LIM_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIM_V);
endmodule

// File: rtl/tg_settle.sv
module tg_settle #(
    parameter int CYCLES = 43
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic ready
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             ready_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            busy_q  <= 1'b1;
            ready_q <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == LAST_V) begin
                busy_q  <= 1'b0;
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ready = ready_q;
endmodule

// File: rtl/tone_guard_latch.sv
module tone_guard_latch
    import tone_guard_pkg::*;
#(
    parameter int PRESENT_TICKS = 30,
    parameter int ABSENT_TICKS  = 30,
    parameter int SETTLE_CYCLES = 43
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              tick,
    input  logic              tone_valid,
    input  logic [1:0]        tone_row,
    input  logic [1:0]        tone_col,
    input  logic              letter_block,
    input  logic              out_en,
    output logic [CODE_W-1:0] code_out,
    output logic              code_drive,
    output logic              key_strobe
);
    steer_state_e      state_q, state_d;
    logic [CODE_W-1:0] code_q;
    key_idx_t          idx;
    logic              pair_ok;
    logic              pres_done, abs_done;
    logic              latch_now, release_now;

    assign idx     = '{row: tone_row, col: tone_col};
    assign pair_ok = tone_valid && !(letter_block && is_letter(idx));

    tg_tick_timer #(.LIMIT(PRESENT_TICKS)) u_pres (
        .clk(clk), .rst(rst),
        .clear(pwr_down || state_q != ST_PRESENT),
        .tick(tick), .done(pres_done)
    );

    tg_tick_timer #(.LIMIT(ABSENT_TICKS)) u_abs (
        .clk(clk), .rst(rst),
        .clear(pwr_down || state_q != ST_ABSENT),
        .tick(tick), .done(abs_done)
    );

    always_comb begin
        state_d     = state_q;
        latch_now   = 1'b0;
        release_now = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (pair_ok) state_d = ST_PRESENT;
            ST_PRESENT: begin
                if (!pair_ok) begin
                    state_d = ST_IDLE;
                end else if (pres_done) begin
                    state_d   = ST_HELD;
                    latch_now = 1'b1;
                end
            end
            ST_HELD:    if (!tone_valid) state_d = ST_ABSENT;
            ST_ABSENT: begin
                if (tone_valid) begin
                    state_d = ST_HELD;
                end else if (abs_done) begin
                    state_d     = ST_IDLE;
                    release_now = 1'b1;
                end
            end
            default:    state_d = ST_IDLE;
        endcase
        if (pwr_down) begin
            state_d   = ST_IDLE;
            latch_now = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (latch_now) code_q <= key_to_code(idx);
        end
    end

    tg_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst(rst),
        .start(latch_now),
        .cancel(pwr_down || release_now),
        .ready(key_strobe)
    );

    assign code_drive = out_en;
    assign code_out   = out_en ? code_q : '0;
endmodule

// File: rtl/tone_guard_chk.sv
module tone_guard_chk
    import tone_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pwr_down,
    input logic              letter_block,
    input logic              tone_valid,
    input logic [1:0]        tone_col,
    input logic              out_en,
    input steer_state_e      state_q,
    input logic [CODE_W-1:0] code_q,
    input logic [CODE_W-1:0] code_out,
    input logic              code_drive,
    input logic              key_strobe
);
    // R4
    code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> !key_strobe);

    // R4
    strobe_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_strobe) |-> $stable(code_q));

    // R1
    latch_src_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> ($past(state_q) == ST_PRESENT && $past(tone_valid)));

    // R5
    letter_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRESENT && letter_block && tone_col == 2'd3 && !pwr_down)
            |=> state_q == ST_IDLE);

    // R6
    bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!code_drive && code_out == '0));

    // R7
    pd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!key_strobe && state_q == ST_IDLE));
endmodule

bind tone_guard_latch tone_guard_chk u_chk (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .letter_block(letter_block),
    .tone_valid(tone_valid), .tone_col(tone_col), .out_en(out_en),
    .state_q(state_q), .code_q(code_q), .code_out(code_out),
    .code_drive(code_drive), .key_strobe(key_strobe)
);

// File: tb/sim_tone_guard_latch.sv
module sim_tone_guard_latch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_down = 1'b0;
    logic       tick = 1'b0;
    logic       tone_valid = 1'b0;
    logic [1:0] tone_row = 2'd0;
    logic [1:0] tone_col = 2'd0;
    logic       letter_block = 1'b0;
    logic       out_en = 1'b1;
    logic [3:0] code_out;
    logic       code_drive;
    logic       key_strobe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [3:0] exp_q[$];

    always #5 clk = ~clk;

    tone_guard_latch #(.PRESENT_TICKS(5), .ABSENT_TICKS(4), .SETTLE_CYCLES(6)) u0 (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .tick(tick),
        .tone_valid(tone_valid), .tone_row(tone_row), .tone_col(tone_col),
        .letter_block(letter_block), .out_en(out_en),
        .code_out(code_out), .code_drive(code_drive), .key_strobe(key_strobe)
    );

    // tick every fourth cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick <= (tdiv == 0);
    end

    // expected key codes written from the requirement table
    function automatic logic [3:0] ref_code(int r, int c);
        logic [3:0] t [0:15];
        t[0]=4'b0001;  t[1]=4'b0010;  t[2]=4'b0011;  t[3]=4'b1101;
        t[4]=4'b0100;  t[5]=4'b0101;  t[6]=4'b0110;  t[7]=4'b1110;
        t[8]=4'b0111;  t[9]=4'b1000;  t[10]=4'b1001; t[11]=4'b1111;
        t[12]=4'b1011; t[13]=4'b1010; t[14]=4'b1100; t[15]=4'b0000;
        return t[r*4+c];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic press(input int r, input int c, input int hold, input bit reg_exp);
        tone_row = 2'(r);
        tone_col = 2'(c);
        if (reg_exp) exp_q.push_back(ref_code(r, c));
        tone_valid = 1'b1;
        repeat (hold) @(negedge clk);
        tone_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: every strobe rise must match the next queued code (R3, R4)
    logic prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (!rst && key_strobe && !prev_strobe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected registration", int'(code_out), 0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check(code_out == e, "R3/R4 code at strobe rise", int'(code_out), int'(e));
            end
        end
        prev_strobe <= key_strobe;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(2);
        check(code_out == 4'h0 && !key_strobe, "R3 reset state", int'(code_out), 0);

        // R3: every key, long press and full release (R8)
        for (int k = 0; k < 16; k++) begin
            press(k / 4, k % 4, 40, 1'b1);
            idle(60);
            check(code_out == ref_code(k / 4, k % 4), "R3 latched code", int'(code_out), int'(ref_code(k / 4, k % 4)));
            check(!key_strobe, "R8 strobe released", int'(key_strobe), 0);
        end

        // R2 / R8: key 5 then release timing
        press(1, 1, 40, 1'b1);
        idle(8);
        check(key_strobe, "R2 strobe held early in absence", int'(key_strobe), 1);
        idle(40);
        check(!key_strobe, "R8 strobe falls after absence guard", int'(key_strobe), 0);

        // R1: short burst of key 1
        press(0, 0, 12, 1'b0);
        idle(40);
        check(code_out == 4'b0101 && !key_strobe, "R1 short burst ignored", int'(code_out), 5);

        // R2: key 7, dropout, then key 9 during bridged gap
        press(2, 0, 40, 1'b1);
        idle(8);
        check(key_strobe, "R2 dropout keeps strobe", int'(key_strobe), 1);
        press(2, 2, 40, 1'b0);
        check(code_out == 4'b0111 && key_strobe, "R2 no re-registration", int'(code_out), 7);
        idle(60);

        // R5: letter block
        letter_block = 1'b1;
        press(1, 3, 40, 1'b0);
        idle(60);
        check(code_out == 4'b0111 && !key_strobe, "R5 letter blocked", int'(code_out), 7);
        press(0, 1, 40, 1'b1);
        idle(60);
        check(code_out == 4'b0010, "R5 digit with block on", int'(code_out), 2);
        letter_block = 1'b0;

        // R6: output enable
        out_en = 1'b0;
        idle(1);
        check(code_out == 4'h0 && !code_drive, "R6 bus released", int'({code_drive, code_out}), 0);
        out_en = 1'b1;
        idle(1);
        check(code_out == 4'b0010 && code_drive, "R6 bus driven", int'({code_drive, code_out}), 'h12);

        // R7: power-down during presence timing
        tone_row = 2'd0; tone_col = 2'd2; tone_valid = 1'b1;
        idle(8);
        pwr_down = 1'b1;
        idle(40);
        check(!key_strobe && code_out == 4'b0010, "R7 no registration in standby", int'(code_out), 2);
        tone_valid = 1'b0;
        pwr_down = 1'b0;
        idle(20);

        // R7: power-down while registered
        press(2, 1, 40, 1'b1);
        pwr_down = 1'b1;
        idle(2);
        check(!key_strobe, "R7 strobe cleared", int'(key_strobe), 0);
        check(code_out == 4'b1000, "R7 code kept", int'(code_out), 8);
        pwr_down = 1'b0;
        idle(20);

        // R7: usable after power-up
        press(3, 2, 40, 1'b1);
        idle(60);
        check(code_out == 4'b1100, "R7 registers after wake", int'(code_out), 12);

        check(exp_q.size() == 0, "R1 all long presses registered", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule